// File: doc/BRIEF.md
# Clock Synchronizer Mode Controller

This block is the mode sequencer for a network-timing phase-locked loop. Each clock cycle it looks at a two-bit mode request, the identity of the selected reference, a reference-good flag and a reference-rate class. From these it picks one of four operating states: Free-run, Normal (tracking the reference), Holdover (manually requested) or Auto Holdover (entered by itself when the reference is lost). It reports the state together with a LOCK flag and a HOLDOVER flag. The loop arithmetic, the stored holdover frequency and the reference quality measurement all sit outside the block.

When the reference fails, the block leaves Normal for Auto Holdover. It can come back to Normal in one of two ways. Under the automatic policy it returns as soon as the reference is good again. Under the manual policy it waits for a rising edge on the release input that arrives while the reference is good. This manual policy stops an intermittent reference from toggling the loop between tracking and holdover. A low-rate reference (the 8 kHz class) always recovers through Holdover.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While rst_n is low, the state output is Free-run and both flags are 0. State codes are Normal 2'b00, Holdover 2'b01, Free-run 2'b10 and Auto Holdover 2'b11. Every transition below takes effect on the state output one clock edge after the inputs that cause it.
- R2: Mode request 2'b10 moves the machine to Free-run from any state. It has priority over every other condition.
- R3: Mode request 2'b11 is reserved. While it is present, the state does not change.
- R4: In Free-run, mode request 2'b00 with ref_ok high moves the machine to Normal, and mode request 2'b01 moves it to Holdover. Any other combination leaves it in Free-run.
- R5: In Normal, mode request 2'b01 moves the machine to Holdover. A ref_sel value that differs from the one sampled at the previous edge also moves it to Holdover (the sampled value is zero after reset). Both conditions take priority over a reference failure.
- R6: In Normal with mode request 2'b00, ref_ok low and ref_sel unchanged, the machine moves to Auto Holdover. With ref_ok high it stays in Normal.
- R7: In Auto Holdover, mode request 2'b01 or a change of ref_sel moves the machine to Holdover.
- R8: In Auto Holdover with mode request 2'b00, ref_ok high, auto_ret_dis 0, ref_low_rate 0 and ref_sel unchanged, the machine returns to Normal.
- R9: With auto_ret_dis 1, Auto Holdover recovers only in a cycle where man_rel is 1 after being sampled 0 at the previous edge, ref_ok is high and mode request is 2'b00. After reset, man_rel counts as previously 1. A release edge that arrives while ref_ok is low is lost. A level held at 1 does not trigger again.
- R10: When ref_low_rate is 1, a recovery from Auto Holdover that would otherwise go to Normal goes to Holdover instead.
- R11: In Holdover, mode request 2'b00 with ref_ok high moves the machine to Normal. Any other combination, including a change of ref_sel, leaves it in Holdover.
- R12: In Normal, lock_o is 1 and holdover_o is 0. In Holdover and Auto Holdover, lock_o is 0 and holdover_o is 1. In Free-run, both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_sel | input | 2 | Requested mode: 00 Normal, 01 Holdover, 10 Free-run, 11 reserved |
| ref_sel | input | SEL_W | Identity of the selected reference; a change forces Holdover |
| ref_ok | input | 1 | Reference currently judged good |
| ref_low_rate | input | 1 | Reference belongs to the 8 kHz class |
| auto_ret_dis | input | 1 | 1 selects manual release from Auto Holdover |
| man_rel | input | 1 | Manual release request, acts on its rising edge |
| state_o | output | 2 | Current state code |
| lock_o | output | 1 | Loop tracking the reference |
| holdover_o | output | 1 | Loop in either holdover state |

## Verification
The assertions assume that every input is synchronous to clk and settles before each rising edge. They also assume that ref_sel and man_rel are driven low during reset, because their sampled histories start from reset values. The stimulus drives all inputs only on the falling edge and holds them low during reset. The random phase weights the inputs so that reference failures, release edges, rate-class flips, reserved codes and reference-select changes each occur often enough to reach both recovery policies and the forced-Holdover paths.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'b00,
    ST_HOLD   = 2'b01,
    ST_FREE   = 2'b10,
    ST_AUTO   = 2'b11
  } mc_state_e;

  localparam logic [1:0] REQ_NORMAL = 2'b00;
  localparam logic [1:0] REQ_HOLD   = 2'b01;
  localparam logic [1:0] REQ_FREE   = 2'b10;
  localparam logic [1:0] REQ_RSVD   = 2'b11;
endpackage

// File: rtl/mc_input_track.sv
module mc_input_track #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ref_sel,
  input  logic             man_rel,
  output logic             sel_chg,
  output logic             rel_rise
);
  logic [SEL_W-1:0] sel_q;
  logic             rel_q;
  logic             smp_en;

  assign smp_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      rel_q <= 1'b1;
    end else if (smp_en) begin
      sel_q <= ref_sel;
      rel_q <= man_rel;
    end
  end

  always_comb begin
    sel_chg  = (ref_sel != sel_q);
    rel_rise = man_rel & ~rel_q;
  end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_pkg::*;
(
  input  mc_state_e  cur,
  input  logic [1:0] mode_sel,
  input  logic       sel_chg,
  input  logic       ref_ok,
  input  logic       ref_low_rate,
  input  logic       auto_ret_dis,
  input  logic       rel_rise,
  output mc_state_e  nxt
);
  logic track_req;
  logic recover;

  always_comb begin
    track_req = (mode_sel == REQ_NORMAL);
    recover   = track_req & ref_ok & (~auto_ret_dis | rel_rise);
    nxt       = cur;
    if (mode_sel == REQ_FREE) begin
      nxt = ST_FREE;
    end else if (mode_sel != REQ_RSVD) begin
      unique case (cur)
        ST_FREE: begin
          if (mode_sel == REQ_HOLD)   nxt = ST_HOLD;
          else if (track_req && ref_ok) nxt = ST_NORMAL;
        end
        ST_NORMAL: begin
          if (mode_sel == REQ_HOLD || sel_chg) nxt = ST_HOLD;
          else if (track_req && !ref_ok)      nxt = ST_AUTO;
        end
        ST_AUTO: begin
          if (mode_sel == REQ_HOLD || sel_chg) nxt = ST_HOLD;
          else if (recover)                   nxt = ref_low_rate ? ST_HOLD : ST_NORMAL;
        end
        ST_HOLD: begin
          if (track_req && ref_ok) nxt = ST_NORMAL;
        end
        default: nxt = ST_FREE;
      endcase
    end
  end
endmodule

// File: rtl/mc_flag_decode.sv
module mc_flag_decode
  import mc_pkg::*;
(
  input  mc_state_e cur,
  output logic      lock,
  output logic      holdover
);
  always_comb begin
    lock     = 1'b0;
    holdover = 1'b0;
    unique case (cur)
      ST_NORMAL:       lock     = 1'b1;
      ST_HOLD, ST_AUTO: holdover = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
  import mc_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [SEL_W-1:0] ref_sel,
  input  logic             ref_ok,
  input  logic             ref_low_rate,
  input  logic             auto_ret_dis,
  input  logic             man_rel,
  output logic [1:0]       state_o,
  output logic             lock_o,
  output logic             holdover_o
);
  mc_state_e st_q, st_d;
  logic      sel_chg, rel_rise;

  mc_input_track #(.SEL_W(SEL_W)) trk_i (
    .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .man_rel(man_rel),
    .sel_chg(sel_chg), .rel_rise(rel_rise)
  );

  mc_next_state nxt_i (
    .cur(st_q), .mode_sel(mode_sel), .sel_chg(sel_chg), .ref_ok(ref_ok),
    .ref_low_rate(ref_low_rate), .auto_ret_dis(auto_ret_dis),
    .rel_rise(rel_rise), .nxt(st_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FREE;
    else        st_q <= st_d;
  end

  mc_flag_decode dec_i (.cur(st_q), .lock(lock_o), .holdover(holdover_o));

  assign state_o = st_q;

  // R2
  free_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == REQ_FREE) |=> (state_o == ST_FREE));

  // R3
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == REQ_RSVD) |=> $stable(state_o));

  // R6
  normal_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_NORMAL && mode_sel == REQ_NORMAL && !sel_chg && !ref_ok)
    |=> (state_o == ST_AUTO));

  // R8
  auto_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_AUTO && mode_sel == REQ_NORMAL && !sel_chg && ref_ok &&
     !auto_ret_dis && !ref_low_rate) |=> (state_o == ST_NORMAL));

  // R9
  manual_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_AUTO && auto_ret_dis && !rel_rise) |=> (state_o != ST_NORMAL));

  // R12
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lock_o, holdover_o}));
endmodule

// File: tb/sync_mode_ctrl_tb_top.sv
module sync_mode_ctrl_tb_top;
  localparam int SEL_W = 3;
  localparam logic [1:0] S_NORM = 2'b00, S_HOLD = 2'b01, S_FREE = 2'b10, S_AUTO = 2'b11;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode_sel;
  logic [SEL_W-1:0] ref_sel;
  logic ref_ok, ref_low_rate, auto_ret_dis, man_rel;
  logic [1:0] state_o;
  logic lock_o, holdover_o;

  int checks = 0;
  int fails = 0;
  logic [1:0] model;
  logic [SEL_W-1:0] prev_sel;
  logic prev_rel;

  always #2.5 clk = ~clk;

  sync_mode_ctrl #(.SEL_W(SEL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_sel(ref_sel),
    .ref_ok(ref_ok), .ref_low_rate(ref_low_rate), .auto_ret_dis(auto_ret_dis),
    .man_rel(man_rel), .state_o(state_o), .lock_o(lock_o), .holdover_o(holdover_o)
  );

  function automatic logic [1:0] exp_next(logic [1:0] s, logic [1:0] m, logic chg,
                                          logic ok, logic k8, logic dis, logic edg);
    if (m == 2'b10) return S_FREE;
    if (m == 2'b11) return s;
    case (s)
      S_FREE: return (m == 2'b01) ? S_HOLD : ((m == 2'b00 && ok) ? S_NORM : S_FREE);
      S_NORM: return (m == 2'b01 || chg) ? S_HOLD : ((m == 2'b00 && !ok) ? S_AUTO : S_NORM);
      S_AUTO: begin
        if (m == 2'b01 || chg) return S_HOLD;
        if (m == 2'b00 && ok && (!dis || edg)) return k8 ? S_HOLD : S_NORM;
        return S_AUTO;
      end
      default: return (m == 2'b00 && ok) ? S_NORM : S_HOLD;
    endcase
  endfunction

  function automatic string req_tag(logic [1:0] s, logic [1:0] m, logic chg, logic k8, logic dis);
    if (m == 2'b10) return "R2";
    if (m == 2'b11) return "R3";
    case (s)
      S_FREE: return "R4";
      S_NORM: return (m == 2'b01 || chg) ? "R5" : "R6";
      S_AUTO: begin
        if (m == 2'b01 || chg) return "R7";
        if (k8) return "R10";
        return dis ? "R9" : "R8";
      end
      default: return "R11";
    endcase
  endfunction

  task automatic check_flags();
    logic el, eh;
    el = (model == S_NORM);
    eh = (model == S_HOLD || model == S_AUTO);
    checks++;
    if (lock_o !== el || holdover_o !== eh) begin
      fails++;
      $display("FAIL R12: lock/holdover=%b%b expected %b%b", lock_o, holdover_o, el, eh);
    end
  endtask

  task automatic step(logic [1:0] m, logic [SEL_W-1:0] sel, logic ok,
                      logic k8, logic dis, logic rel);
    logic [1:0] exp;
    logic chg, edg;
    string tag;
    @(negedge clk);
    mode_sel = m; ref_sel = sel; ref_ok = ok; ref_low_rate = k8;
    auto_ret_dis = dis; man_rel = rel;
    chg = (sel != prev_sel);
    edg = rel & ~prev_rel;
    exp = exp_next(model, m, chg, ok, k8, dis, edg);
    tag = req_tag(model, m, chg, k8, dis);
    @(posedge clk);
    #1;
    prev_sel = sel;
    prev_rel = rel;
    model = exp;
    checks++;
    if (state_o !== exp) begin
      fails++;
      $display("FAIL %s: state=%b expected %b", tag, state_o, exp);
    end
    check_flags();
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b00; ref_sel = '0; ref_ok = 1'b0;
    ref_low_rate = 1'b0; auto_ret_dis = 1'b0; man_rel = 1'b0;
    model = S_FREE; prev_sel = '0; prev_rel = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (state_o !== S_FREE) begin
      fails++;
      $display("FAIL R1: state=%b expected %b", state_o, S_FREE);
    end
    check_flags();
    @(negedge clk);
    rst_n = 1'b1;

    // R4 free-run stays without good reference, then enters Normal
    step(2'b00, 0, 0, 0, 0, 0);
    step(2'b00, 0, 1, 0, 0, 0);
    // R6 reference loss, R8 automatic return
    step(2'b00, 0, 0, 0, 0, 0);
    step(2'b00, 0, 1, 0, 0, 0);
    // R9 manual policy: no edge, edge while bad lost, held level, fresh edge
    step(2'b00, 0, 0, 0, 1, 0);
    step(2'b00, 0, 1, 0, 1, 0);
    step(2'b00, 0, 0, 0, 1, 1);
    step(2'b00, 0, 1, 0, 1, 1);
    step(2'b00, 0, 1, 0, 1, 0);
    step(2'b00, 0, 1, 0, 1, 1);
    // R10 low-rate recovery via Holdover, then R11 to Normal
    step(2'b00, 0, 0, 1, 0, 0);
    step(2'b00, 0, 1, 1, 0, 0);
    step(2'b00, 0, 0, 0, 0, 0);
    step(2'b00, 0, 1, 0, 0, 0);
    // R5 reference select change beats a failure
    step(2'b00, 3, 0, 0, 0, 0);
    // R11 select change in Holdover ignored; R3 reserved hold; R2 force
    step(2'b11, 5, 1, 0, 0, 0);
    step(2'b01, 6, 1, 0, 0, 0);
    step(2'b00, 6, 1, 0, 0, 0);
    step(2'b11, 6, 0, 0, 0, 0);
    step(2'b00, 6, 0, 0, 0, 0);
    step(2'b01, 6, 0, 0, 0, 0);
    // R7 from Auto Holdover via mode 01
    step(2'b00, 6, 1, 0, 0, 0);
    step(2'b00, 6, 0, 0, 0, 0);
    step(2'b01, 6, 0, 0, 0, 0);
    step(2'b10, 6, 1, 0, 0, 0);

    begin
      int seed;
      seed = 32'h5eed;
      void'($urandom(seed));
    end
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] m;
      logic [SEL_W-1:0] sel;
      int r;
      r = $urandom_range(0, 99);
      m = (r < 70) ? 2'b00 : (r < 85) ? 2'b01 : (r < 93) ? 2'b11 : 2'b10;
      sel = ($urandom_range(0, 99) < 5) ? SEL_W'($urandom) : prev_sel;
      step(m, sel, $urandom_range(0, 99) < 65, $urandom_range(0, 99) < 20,
           $urandom_range(0, 1) == 1, $urandom_range(0, 99) < 30);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule